// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This unit executes the 32-bit basic bit-manipulation operations for an integer pipeline. Each issue carries an operation code, two register operands and a 5-bit immediate. One cycle later the unit returns a single 32-bit writeback value. The operations fall into four groups:

- logic with an inverted second operand;
- bit counting: leading zeros, trailing zeros and ones;
- signed and unsigned minimum and maximum;
- data rearrangement: sign and zero extension, rotates, a per-byte OR-combine and byte reversal.

All datapaths are combinational. A single output register, together with a valid flag, sits after the result select to give timing margin. Decode, operand fetch and hazard handling are done elsewhere in the pipeline.

The issue interface has no backpressure. When `in_valid` is high at a rising edge, the operation is captured, and its result appears at the outputs after that edge.

Top module: `bmu_alu`

## Requirements
- R1: Op code 0 returns rs1 & ~rs2, code 1 returns rs1 | ~rs2, and code 2 returns ~(rs1 ^ rs2).
- R2: Op code 3 returns the number of leading zero bits of rs1, zero-extended to 32 bits, and returns 32 when rs1 is zero.
- R3: Op code 4 returns the number of trailing zero bits of rs1, and returns 32 when rs1 is zero.
- R4: Op code 5 returns the number of set bits in rs1.
- R5: Op code 6 returns the smaller and op code 8 the larger of rs1 and rs2, both compared as two's-complement values.
- R6: Op code 7 returns the smaller and op code 9 the larger of rs1 and rs2, both compared as unsigned values.
- R7: Op code 10 copies bit 7 of rs1 into bits 31:8. Op code 11 copies bit 15 into bits 31:16. Op code 12 clears bits 31:16. The low byte or halfword passes through unchanged in each case.
- R8: Op code 13 rotates rs1 left and op code 14 rotates it right, each by rs2[4:0]. Bits 31:5 of rs2 have no effect on the result.
- R9: Op code 15 rotates rs1 right by the immediate. rs2 has no effect on the result.
- R10: Op code 16 sets each result byte to 0xFF when the byte of rs1 in the same position is nonzero, and to 0x00 when it is zero.
- R11: Op code 17 reverses the byte order of rs1, so that result byte k equals rs1 byte 3-k.
- R12: Op codes 18 to 31 return a zero result with `illegal_op` high. Every legal code returns `illegal_op` low.
- R13: After reset, `out_valid`, `result` and `illegal_op` are all zero. The outputs of an operation captured at a rising edge appear after that edge. `out_valid` in each cycle equals `in_valid` at the previous edge. While `in_valid` is low, `result` and `illegal_op` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Issue strobe; operands are captured at the rising edge |
| op | input | 5 | Operation code |
| rs1 | input | 32 | First register operand |
| rs2 | input | 32 | Second register operand |
| imm | input | 5 | Immediate rotate amount |
| out_valid | output | 1 | Result register holds a fresh operation |
| result | output | 32 | Writeback value |
| illegal_op | output | 1 | Captured op code was outside the legal set |

## Verification
The properties assume that every input is at a known value at each rising edge while reset is released. They make no assumption about which op codes arrive, or in what order, so illegal codes and idle cycles are both allowed. The stimulus changes inputs only at falling edges, so no input can be X when it is sampled. Random op codes are drawn from the full 5-bit range, which exercises the illegal codes. The directed phase sweeps every legal code across the extreme operand values and both end rotate amounts.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

    localparam int OP_W     = 5;
    localparam int NUM_OPS  = 18;

    typedef enum logic [OP_W-1:0] {
        OP_ANDN  = 5'd0,
        OP_ORN   = 5'd1,
        OP_XNOR  = 5'd2,
        OP_CLZ   = 5'd3,
        OP_CTZ   = 5'd4,
        OP_CPOP  = 5'd5,
        OP_MIN   = 5'd6,
        OP_MINU  = 5'd7,
        OP_MAX   = 5'd8,
        OP_MAXU  = 5'd9,
        OP_SEXTB = 5'd10,
        OP_SEXTH = 5'd11,
        OP_ZEXTH = 5'd12,
        OP_ROL   = 5'd13,
        OP_ROR   = 5'd14,
        OP_RORI  = 5'd15,
        OP_ORCB  = 5'd16,
        OP_REV8  = 5'd17
    } bmu_op_e;

endpackage

// File: rtl/bmu_count.sv
module bmu_count #(
    parameter int XLEN = 32,
    localparam int CW  = $clog2(XLEN) + 1
) (
    input  logic [XLEN-1:0] src,
    output logic [CW-1:0]   lead_zeros,
    output logic [CW-1:0]   trail_zeros,
    output logic [CW-1:0]   ones
);

    always_comb begin
        lead_zeros = CW'(XLEN);
        for (int i = 0; i < XLEN; i++) begin
            if (src[i]) lead_zeros = CW'(XLEN - 1 - i);
        end
    end

    always_comb begin
        trail_zeros = CW'(XLEN);
        for (int i = XLEN - 1; i >= 0; i--) begin
            if (src[i]) trail_zeros = CW'(i);
        end
    end

    always_comb begin
        ones = '0;
        for (int i = 0; i < XLEN; i++) begin
            ones = ones + CW'(src[i]);
        end
    end

endmodule

// File: rtl/bmu_perm.sv
module bmu_perm #(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN),
    localparam int NB  = XLEN / 8
) (
    input  logic [XLEN-1:0] src,
    input  logic [SHW-1:0]  amt,
    input  logic            dir_left,
    output logic [XLEN-1:0] rotated,
    output logic [XLEN-1:0] byte_rev,
    output logic [XLEN-1:0] byte_orc
);

    logic [2*XLEN-1:0] dbl_l;
    logic [2*XLEN-1:0] dbl_r;

    always_comb begin
        dbl_l   = {src, src} << amt;
        dbl_r   = {src, src} >> amt;
        rotated = dir_left ? dbl_l[2*XLEN-1:XLEN] : dbl_r[XLEN-1:0];
    end

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign byte_rev[8*b +: 8] = src[8*(NB-1-b) +: 8];
        assign byte_orc[8*b +: 8] = {8{|src[8*b +: 8]}};
    end

endmodule

// File: rtl/bmu_cmp.sv
module bmu_cmp #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            lt_signed,
    output logic            lt_unsigned
);

    always_comb begin
        lt_unsigned = a < b;
        lt_signed   = (a[XLEN-1] != b[XLEN-1]) ? a[XLEN-1] : lt_unsigned;
    end

endmodule

// File: rtl/bmu_alu.sv
module bmu_alu
    import bmu_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN),
    localparam int CW  = $clog2(XLEN) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [OP_W-1:0] op,
    input  logic [XLEN-1:0] rs1,
    input  logic [XLEN-1:0] rs2,
    input  logic [SHW-1:0]  imm,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic            illegal_op
);

    typedef struct packed {
        logic            vld;
        logic            bad;
        logic [XLEN-1:0] res;
    } out_state_t;

    out_state_t state_d, state_q;

    logic [CW-1:0]   cnt_lz, cnt_tz, cnt_pop;
    logic            lt_s, lt_u;
    logic [SHW-1:0]  rot_amt;
    logic            rot_left;
    logic [XLEN-1:0] rot_res, rev_res, orc_res;
    bmu_op_e         op_e;

    assign op_e     = bmu_op_e'(op);
    assign rot_amt  = (op_e == OP_RORI) ? imm : rs2[SHW-1:0];
    assign rot_left = (op_e == OP_ROL);

    bmu_count #(.XLEN(XLEN)) u_count (
        .src         (rs1),
        .lead_zeros  (cnt_lz),
        .trail_zeros (cnt_tz),
        .ones        (cnt_pop)
    );

    bmu_cmp #(.XLEN(XLEN)) u_cmp (
        .a           (rs1),
        .b           (rs2),
        .lt_signed   (lt_s),
        .lt_unsigned (lt_u)
    );

    bmu_perm #(.XLEN(XLEN)) u_perm (
        .src      (rs1),
        .amt      (rot_amt),
        .dir_left (rot_left),
        .rotated  (rot_res),
        .byte_rev (rev_res),
        .byte_orc (orc_res)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.bad = 1'b0;
            unique case (op_e)
                OP_ANDN:  state_d.res = rs1 & ~rs2;
                OP_ORN:   state_d.res = rs1 | ~rs2;
                OP_XNOR:  state_d.res = ~(rs1 ^ rs2);
                OP_CLZ:   state_d.res = XLEN'(cnt_lz);
                OP_CTZ:   state_d.res = XLEN'(cnt_tz);
                OP_CPOP:  state_d.res = XLEN'(cnt_pop);
                OP_MIN:   state_d.res = lt_s ? rs1 : rs2;
                OP_MAX:   state_d.res = lt_s ? rs2 : rs1;
                OP_MINU:  state_d.res = lt_u ? rs1 : rs2;
                OP_MAXU:  state_d.res = lt_u ? rs2 : rs1;
                OP_SEXTB: state_d.res = {{(XLEN-8){rs1[7]}}, rs1[7:0]};
                OP_SEXTH: state_d.res = {{(XLEN-16){rs1[15]}}, rs1[15:0]};
                OP_ZEXTH: state_d.res = {{(XLEN-16){1'b0}}, rs1[15:0]};
                OP_ROL, OP_ROR, OP_RORI: state_d.res = rot_res;
                OP_ORCB:  state_d.res = orc_res;
                OP_REV8:  state_d.res = rev_res;
                default: begin
                    state_d.res = '0;
                    state_d.bad = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid  = state_q.vld;
    assign result     = state_q.res;
    assign illegal_op = state_q.bad;

endmodule

// File: rtl/bmu_alu_chk.sv
module bmu_alu_chk
    import bmu_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [OP_W-1:0] op,
    input logic [XLEN-1:0] rs1,
    input logic [XLEN-1:0] rs2,
    input logic [SHW-1:0]  imm,
    input logic            out_valid,
    input logic [XLEN-1:0] result,
    input logic            illegal_op
);

    assert_valid_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(illegal_op)));

    assert_illegal_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op >= OP_W'(NUM_OPS)) |=> (illegal_op && result == '0));

    assert_legal_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op < OP_W'(NUM_OPS)) |=> !illegal_op);

    assert_popcount_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_CPOP) |=> (result == XLEN'($countones($past(rs1)))));

    assert_zext_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_ZEXTH) |=> (result[XLEN-1:16] == '0));

    assert_orc_bytes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_ORCB) |=> ($countones(result) % 8 == 0));

endmodule

bind bmu_alu bmu_alu_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op         (op),
    .rs1        (rs1),
    .rs2        (rs2),
    .imm        (imm),
    .out_valid  (out_valid),
    .result     (result),
    .illegal_op (illegal_op)
);

// File: tb/bmu_alu_tb.sv
`timescale 1ns/1ps
module bmu_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op = '0;
    logic [31:0] rs1 = '0;
    logic [31:0] rs2 = '0;
    logic [4:0]  imm = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        illegal_op;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bmu_alu u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .rs1(rs1), .rs2(rs2), .imm(imm),
        .out_valid(out_valid), .result(result), .illegal_op(illegal_op)
    );

    function automatic string tag_of(logic [4:0] o);
        if (o <= 2)        return "R1";
        else if (o == 3)   return "R2";
        else if (o == 4)   return "R3";
        else if (o == 5)   return "R4";
        else if (o == 6 || o == 8) return "R5";
        else if (o == 7 || o == 9) return "R6";
        else if (o <= 12)  return "R7";
        else if (o <= 14)  return "R8";
        else if (o == 15)  return "R9";
        else if (o == 16)  return "R10";
        else if (o == 17)  return "R11";
        return "R12";
    endfunction

    function automatic logic [31:0] rotr(logic [31:0] v, int n);
        logic [31:0] t = v;
        for (int k = 0; k < n; k++) t = {t[0], t[31:1]};
        return t;
    endfunction

    function automatic logic [31:0] model(logic [4:0] o, logic [31:0] a,
                                          logic [31:0] b, logic [4:0] im);
        int n;
        logic [31:0] r;
        case (o)
            0: return a & ~b;
            1: return a | ~b;
            2: return ~(a ^ b);
            3: begin n = 0; while (n < 32 && !a[31-n]) n++; return 32'(n); end
            4: begin n = 0; while (n < 32 && !a[n]) n++; return 32'(n); end
            5: begin n = 0; for (int k = 0; k < 32; k++) n += int'(a[k]); return 32'(n); end
            6: return ($signed(a) < $signed(b)) ? a : b;
            7: return (a < b) ? a : b;
            8: return ($signed(a) > $signed(b)) ? a : b;
            9: return (a > b) ? a : b;
            10: return 32'($signed(a[7:0]));
            11: return 32'($signed(a[15:0]));
            12: return {16'h0, a[15:0]};
            13: return rotr(a, (32 - int'(b[4:0])) % 32);
            14: return rotr(a, int'(b[4:0]));
            15: return rotr(a, int'(im));
            16: begin
                for (int k = 0; k < 4; k++) r[8*k +: 8] = (a[8*k +: 8] != 0) ? 8'hFF : 8'h00;
                return r;
            end
            17: return {a[7:0], a[15:8], a[23:16], a[31:24]};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(logic [4:0] o, logic [31:0] a, logic [31:0] b, logic [4:0] im);
        logic [31:0] exp;
        @(negedge clk);
        op = o; rs1 = a; rs2 = b; imm = im; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        exp = model(o, a, b, im);
        check(tag_of(o), $sformatf("op %0d result", o), result, exp);
        check("R12", $sformatf("op %0d illegal flag", o), 32'(illegal_op), 32'(o > 17));
        check("R13", "out_valid after issue", 32'(out_valid), 32'd1);
    endtask

    logic [31:0] corners [8] = '{32'h0, 32'hFFFFFFFF, 32'h80000000, 32'h7FFFFFFF,
                                 32'h00000001, 32'h00010000, 32'h00000080, 32'h12F0_0A81};

    initial begin
        void'($urandom(32'h5EED_0BB1));
        #1;
        check("R13", "reset out_valid", 32'(out_valid), 32'd0);
        check("R13", "reset result", result, 32'd0);
        check("R13", "reset illegal_op", 32'(illegal_op), 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // directed sweep of every legal op over corner operands, amounts 0 and 31
        for (int o = 0; o < 18; o++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++) begin
                    run_op(5'(o), corners[i], corners[j], 5'd0);
                    run_op(5'(o), corners[i], corners[j] | 32'd31, 5'd31);
                end

        // R8: upper rs2 bits ignored; R9: rs2 ignored for immediate rotate
        run_op(5'd13, 32'h8000_0001, 32'hFFFF_FFE1, 5'd0);
        run_op(5'd14, 32'h8000_0001, 32'hABCD_EF03, 5'd0);
        run_op(5'd15, 32'h1234_5678, 32'h0000_0010, 5'd4);

        // R12: every illegal code
        for (int o = 18; o < 32; o++) run_op(5'(o), 32'hDEAD_BEEF, 32'h1, 5'd3);

        // R13: hold while idle
        run_op(5'd17, 32'h0102_0304, 32'h0, 5'd0);
        @(negedge clk);
        op = 5'd0; rs1 = 32'hFFFF_FFFF; rs2 = 32'h0;
        @(negedge clk);
        check("R13", "out_valid low when idle", 32'(out_valid), 32'd0);
        check("R13", "result held when idle", result, 32'h0403_0201);
        check("R13", "illegal_op held when idle", 32'(illegal_op), 32'd0);

        // constrained random: operands biased toward corners
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] a, b;
            a = ($urandom % 4 == 0) ? corners[$urandom % 8] : $urandom;
            b = ($urandom % 4 == 0) ? corners[$urandom % 8] : $urandom;
            if ($urandom % 3 == 0) a = 32'(1) << ($urandom % 32);
            run_op(5'($urandom % 32), a, b, 5'($urandom));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule